// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. A tick input, running at sixteen times the baud rate, marks each oversample. The line first passes through a two-stage synchroniser. A start condition is only accepted once the line has stayed low for half a bit period of consecutive samples. From that point, which is the middle of the start bit, the block takes one sample every full bit period. These samples give the data bits, an optional parity bit and one stop bit.

The character length is configurable from five to eight bits, with a separate nine-bit mode. The bit order can be least- or most-significant first. Parity can be even, odd, forced low, forced high or absent. The configuration is captured when a start is accepted. The block checks exactly one stop bit whatever the transmitter uses, and it returns to hunting for a start bit as soon as that stop sample is taken. When the stop bit is sampled, the character is presented on the data port with a one-cycle valid strobe and the parity and framing flags.

Top module: `serial_rx16`

## Requirements
- R1: While reset is held and directly after it, `rx_valid`, `rx_par_err` and `rx_frm_err` are 0 and `rx_data` is 0.
- R2: A start is accepted only after 8 consecutive low samples (OSR/2) taken on ticks. A low pulse shorter than that returns the receiver to idle and produces no character.
- R3: After start acceptance each bit is sampled once every 16 ticks. The length is 5 + `cfg_len` bits (`cfg_len` 0..3), or 9 bits when `cfg_nine` is 1. Bits of `rx_data` above the length read 0.
- R4: With `cfg_msb_first` = 0 the first received data bit lands in `rx_data[0]`. With 1 it lands in `rx_data[n-1]`, where n is the length.
- R5: `cfg_parity` 0 = even, 1 = odd, 2 = parity bit must be 0, 3 = parity bit must be 1. A received parity bit that differs from this sets `rx_par_err` with the character.
- R6: `cfg_parity` 4..7 = no parity bit. The stop bit directly follows the data, and `rx_par_err` stays 0.
- R7: Exactly one stop bit is checked. A low stop sample sets `rx_frm_err`.
- R8: Characters sent back to back with a single stop bit are all received.
- R9: `rx_valid` is a one-cycle pulse issued once per character. The error flags are only ever 1 together with it.
- R10: The configuration is captured at start acceptance. Changing the configuration inputs during a character does not alter that character.
- R11: Nothing advances on cycles without `os_tick`. Characters are received correctly when ticks come only every third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit period |
| rx_line | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_nine | input | 1 | Nine-bit character mode |
| cfg_msb_first | input | 1 | Most significant bit first |
| cfg_parity | input | 3 | Parity mode code |
| rx_data | output | 9 | Received character, right aligned |
| rx_valid | output | 1 | Character strobe |
| rx_par_err | output | 1 | Parity mismatch, with strobe |
| rx_frm_err | output | 1 | Low stop sample, with strobe |

## Verification
The assertions check on every cycle that a high sample during start qualification aborts to idle, and that the sequencer freezes without a tick. They also check that the receiver is idle right after its stop sample, that the strobe is a single cycle with flags only beside it, that unused high data bits are zero, and that no parity error appears when parity is off. The bench scenarios are needed to show the rest. That covers the actual bit values and order, the parity arithmetic in each mode, glitch rejection at the port, framing on a low stop, back-to-back characters, immunity to mid-character configuration changes and operation at a slower tick rate.

// File: rtl/serial_rx16_pkg.sv
package serial_rx16_pkg;

  localparam int unsigned CHAR_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_QUAL,
    ST_BITS
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_DATA,
    PH_PAR,
    PH_STOP
  } rx_phase_e;

  typedef enum logic [1:0] {
    PK_EVEN = 2'd0,
    PK_ODD  = 2'd1,
    PK_ZERO = 2'd2,
    PK_ONE  = 2'd3
  } par_kind_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       msb_first;
    logic       par_en;
    par_kind_e  par_kind;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_cfg(input logic [1:0] len,
                                            input logic       nine,
                                            input logic       msb,
                                            input logic [2:0] par);
    frame_cfg_t c;
    c.nbits     = nine ? 4'd9 : (4'd5 + {2'b00, len});
    c.msb_first = msb;
    c.par_en    = ~par[2];
    c.par_kind  = par_kind_e'(par[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/serial_rx16_sync.sv
module serial_rx16_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx16_ctrl.sv
module serial_rx16_ctrl
  import serial_rx16_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  input  frame_cfg_t cfg_i,
  output frame_cfg_t cfg_q_o,
  output logic       start_ok_o,
  output logic       samp_o,
  output rx_phase_e  phase_o,
  output logic [3:0] idx_o
);

  localparam int unsigned CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int unsigned HALF = OSR / 2;

  rx_state_e  state_q, state_d;
  rx_phase_e  phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0] idx_q, idx_d;
  frame_cfg_t cfg_q, cfg_d;
  logic       start_ok, samp;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    cfg_d    = cfg_q;
    start_ok = 1'b0;
    samp     = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line_i) begin
            state_d = ST_QUAL;
            cnt_d   = CW'(1);
          end
        end
        ST_QUAL: begin
          if (line_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == CW'(HALF - 1)) begin
            start_ok = 1'b1;
            state_d  = ST_BITS;
            phase_d  = PH_DATA;
            cnt_d    = '0;
            idx_d    = '0;
            cfg_d    = cfg_i;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_BITS: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            samp  = 1'b1;
            unique case (phase_q)
              PH_DATA: begin
                if (idx_q == cfg_q.nbits - 4'd1) begin
                  idx_d   = '0;
                  phase_d = cfg_q.par_en ? PH_PAR : PH_STOP;
                end else begin
                  idx_d = idx_q + 4'd1;
                end
              end
              PH_PAR:  phase_d = PH_STOP;
              default: state_d = ST_IDLE;
            endcase
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      idx_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_q_o    = cfg_q;
  assign start_ok_o = start_ok;
  assign samp_o     = samp;
  assign phase_o    = phase_q;
  assign idx_o      = idx_q;

  // R2: a high sample while qualifying a start drops back to idle
  a_r2_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUAL && tick_i && line_i) |=> (state_q == ST_IDLE));

  // R11: without a tick the sequencer holds
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(state_q) && $stable(cnt_q) && $stable(idx_q)));

  // R7: hunting restarts right after the single stop sample
  a_r7_stop_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (samp && phase_q == PH_STOP) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/serial_rx16_asm.sv
module serial_rx16_asm
  import serial_rx16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  frame_cfg_t        cfg_i,
  input  logic              start_ok_i,
  input  logic              samp_i,
  input  rx_phase_e         phase_i,
  input  logic [3:0]        idx_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o
);

  logic [CHAR_W-1:0] acc_q, acc_d;
  logic              pbit_q, pbit_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d;
  logic [3:0]        pos;
  logic              exp_par;

  assign pos = cfg_i.msb_first ? (cfg_i.nbits - 4'd1 - idx_i) : idx_i;

  always_comb begin
    unique case (cfg_i.par_kind)
      PK_EVEN: exp_par = ^acc_q;
      PK_ODD:  exp_par = ~(^acc_q);
      PK_ZERO: exp_par = 1'b0;
      default: exp_par = 1'b1;
    endcase
  end

  always_comb begin
    acc_d   = acc_q;
    pbit_d  = pbit_q;
    data_d  = data_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;
    if (start_ok_i) begin
      acc_d  = '0;
      pbit_d = 1'b0;
    end else if (samp_i) begin
      unique case (phase_i)
        PH_DATA: begin
          for (int b = 0; b < CHAR_W; b++) begin
            if (pos == 4'(b)) acc_d[b] = line_i;
          end
        end
        PH_PAR: pbit_d = line_i;
        default: begin
          data_d  = acc_q;
          valid_d = 1'b1;
          perr_d  = cfg_i.par_en & (pbit_q ^ exp_par);
          ferr_d  = ~line_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pbit_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pbit_q  <= pbit_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;

  // R9: strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9: flags only beside the strobe
  a_r9_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q || ferr_q) |-> valid_q);

  // R3: bits above the character length are zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((data_q >> cfg_i.nbits) == '0));

  // R6: no parity error when parity is off
  a_r6_no_perr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cfg_i.par_en) |-> !perr_q);

endmodule

// File: rtl/serial_rx16.sv
module serial_rx16
  import serial_rx16_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_nine,
  input  logic       cfg_msb_first,
  input  logic [2:0] cfg_parity,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err
);

  logic       rst_n_s;
  logic       line_s;
  frame_cfg_t cfg_in, cfg_q;
  logic       start_ok, samp;
  rx_phase_e  phase;
  logic [3:0] idx;

  serial_rx16_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  serial_rx16_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(rx_line), .q_o(line_s)
  );

  assign cfg_in = decode_cfg(cfg_len, cfg_nine, cfg_msb_first, cfg_parity);

  serial_rx16_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .tick_i(os_tick), .line_i(line_s),
    .cfg_i(cfg_in), .cfg_q_o(cfg_q), .start_ok_o(start_ok),
    .samp_o(samp), .phase_o(phase), .idx_o(idx)
  );

  serial_rx16_asm u_asm (
    .clk(clk), .rst_n(rst_n_s), .line_i(line_s), .cfg_i(cfg_q),
    .start_ok_i(start_ok), .samp_i(samp), .phase_i(phase), .idx_i(idx),
    .data_o(rx_data), .valid_o(rx_valid), .perr_o(rx_par_err),
    .ferr_o(rx_frm_err)
  );

endmodule

// File: tb/serial_rx16_tb_top.sv
module serial_rx16_tb_top;

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       rx_line;
  logic [1:0] cfg_len;
  logic       cfg_nine;
  logic       cfg_msb_first;
  logic [2:0] cfg_parity;
  logic [8:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err;

  int tests_run;
  int tests_failed;
  int tick_div;
  int div_cnt;

  typedef struct {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  serial_rx16 dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_msb_first(cfg_msb_first),
    .cfg_parity(cfg_parity), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (div_cnt >= tick_div - 1) div_cnt <= 0;
    else                         div_cnt <= div_cnt + 1;
  end
  assign os_tick = (div_cnt == 0);

  task automatic hold(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (os_tick) k++;
    end
  endtask

  function automatic logic exp_parity(input logic [8:0] d, input logic [2:0] p);
    case (p)
      3'd0:    return ^d;
      3'd1:    return ~(^d);
      3'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send_char(input logic [8:0] d, input int nb, input bit msb,
                           input logic [2:0] par, input bit bad_par,
                           input bit stop_hi, input bit scramble,
                           input string tag);
    exp_t e;
    logic [8:0] m;
    logic pb;
    m = d & ((9'h1 << nb) - 9'h1);
    cfg_nine      = (nb == 9);
    cfg_len       = (nb == 9) ? 2'd3 : 2'(nb - 5);
    cfg_msb_first = msb;
    cfg_parity    = par;
    e.data = m;
    e.perr = (par < 3'd4) && bad_par;
    e.ferr = !stop_hi;
    e.tag  = tag;
    exp_q.push_back(e);
    rx_line = 1'b0;
    hold(16);
    if (scramble) begin
      cfg_nine      = ~cfg_nine;
      cfg_len       = ~cfg_len;
      cfg_msb_first = ~cfg_msb_first;
      cfg_parity    = (par < 3'd4) ? 3'd4 : 3'd0;
    end
    for (int i = 0; i < nb; i++) begin
      rx_line = msb ? m[nb-1-i] : m[i];
      hold(16);
    end
    if (par < 3'd4) begin
      pb = exp_parity(m, par) ^ bad_par;
      rx_line = pb;
      hold(16);
    end
    if (stop_hi) begin
      rx_line = 1'b1;
      hold(16);
    end else begin
      rx_line = 1'b0;
      hold(12);
      rx_line = 1'b1;
      hold(4);
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rx_valid === 1'b1) begin
        tests_run++;
        if (exp_q.size() == 0) begin
          tests_failed++;
          $display("FAIL R2 unexpected character: data=%h expected no output", rx_data);
        end else begin
          e = exp_q.pop_front();
          if (rx_data !== e.data || rx_par_err !== e.perr || rx_frm_err !== e.ferr) begin
            tests_failed++;
            $display("FAIL %s data/perr/ferr actual=%h/%b/%b expected=%h/%b/%b",
                     e.tag, rx_data, rx_par_err, rx_frm_err, e.data, e.perr, e.ferr);
          end
        end
        @(negedge clk);
        tests_run++;
        if (rx_valid !== 1'b0 || rx_par_err !== 1'b0 || rx_frm_err !== 1'b0) begin
          tests_failed++;
          $display("FAIL R9 strobe width: valid/perr/ferr actual=%b/%b/%b expected=0/0/0",
                   rx_valid, rx_par_err, rx_frm_err);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    tests_run = 0;
    tests_failed = 0;
    tick_div = 1;
    div_cnt = 0;
    rst_n = 1'b0;
    rx_line = 1'b1;
    cfg_len = 2'd3;
    cfg_nine = 1'b0;
    cfg_msb_first = 1'b0;
    cfg_parity = 3'd4;
    repeat (5) @(negedge clk);
    tests_run++;
    if (rx_valid !== 1'b0 || rx_data !== 9'h0 || rx_par_err !== 1'b0 || rx_frm_err !== 1'b0) begin
      tests_failed++;
      $display("FAIL R1 reset outputs actual=%b/%h/%b/%b expected=0/000/0/0",
               rx_valid, rx_data, rx_par_err, rx_frm_err);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    tests_run++;
    if (rx_valid !== 1'b0 || rx_data !== 9'h0) begin
      tests_failed++;
      $display("FAIL R1 after release actual=%b/%h expected=0/000", rx_valid, rx_data);
    end
    hold(20);

    send_char(9'h0A5, 8, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, "R3 R4 lsb-first 8 bit");
    send_char(9'h0A5, 8, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0, "R4 msb-first 8 bit");
    send_char(9'h013, 5, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, "R5 5 bit even");
    send_char(9'h02D, 6, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, "R5 6 bit odd msb");
    send_char(9'h07F, 7, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, "R5 7 bit forced 0");
    send_char(9'h0C3, 8, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, "R5 8 bit forced 1");
    send_char(9'h0C3, 8, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, "R5 even mismatch");
    send_char(9'h011, 5, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, "R5 forced 1 mismatch");
    send_char(9'h1A5, 9, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, "R3 nine bit even");
    send_char(9'h1A5, 9, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, "R3 R4 nine bit msb odd bad");
    send_char(9'h1FF, 5, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0, "R6 R3 masked no parity");

    // R2: short low pulse must produce nothing
    rx_line = 1'b0;
    hold(6);
    rx_line = 1'b1;
    hold(40);
    rx_line = 1'b0;
    hold(7);
    rx_line = 1'b1;
    hold(40);
    send_char(9'h05A, 8, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, "R2 after glitches");

    send_char(9'h0F0, 8, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, "R7 low stop");
    hold(20);
    send_char(9'h00F, 8, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R7 low stop with parity");
    hold(20);

    // R8: back to back, single stop bit
    send_char(9'h001, 8, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, "R8 back-to-back a");
    send_char(9'h080, 8, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, "R8 back-to-back b");
    send_char(9'h055, 7, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, "R8 back-to-back c");

    send_char(9'h0B6, 8, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, "R10 config change mid-char");
    send_char(9'h016, 5, 1'b1, 3'd4, 1'b0, 1'b1, 1'b1, "R10 config change no parity");

    tick_div = 3;
    hold(20);
    send_char(9'h13C, 9, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, "R11 slow tick nine bit");
    send_char(9'h02A, 6, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, "R11 slow tick bad parity");
    hold(40);

    tests_run++;
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R8 missing characters actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule